// File: doc/BRIEF.md
# Fixed-Point Vector Lane Arithmetic Unit

This block is one lane of the arithmetic datapath of a soft vector coprocessor. Each accepted beat carries one element from each of two source vector registers, the current contents of the destination element, a five-bit shift amount, a per-element predicate bit and a four-bit operation code. Two clock edges later the lane presents the element result together with a write-enable for the destination register file and an illegal-operation flag.

The operation set covers wrapping integer add and subtract, signed minimum and maximum, saturating absolute value, a low-half multiply, saturating add and subtract, and a fixed-point multiply whose full product is clamped to the lane width and then arithmetically shifted right. The lane width is a parameter from 1 to 32 bits. Each operation group has its own enable parameter, and a disabled group builds no logic, so a customised coprocessor only carries the arithmetic its program uses.

Operands enter and results leave through valid/ready streams. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high; a result leaves on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its flags stay frozen and the whole pipeline stalls, so `in_ready` drops once both stages hold data. The source side may not withdraw or change a beat while it waits for `in_ready`.

Top module: `vlane_alu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Op code 0 returns a+b and op code 1 returns a-b, both taken modulo 2^W (they wrap, they do not clamp).
- R3: Op code 2 returns the smaller and op code 3 the larger of a and b, both compared as signed W-bit values.
- R4: Op code 4 returns the absolute value of signed a; the most negative value returns the most positive value 2^(W-1)-1.
- R5: Op code 5 returns the low W bits of the signed product a*b.
- R6: Op codes 6 and 7 return a+b and a-b clamped to the signed range [-2^(W-1), 2^(W-1)-1]; they never wrap.
- R7: Op code 8 forms the full signed product a*b, clamps it to the signed W-bit range, then shifts the clamped value right arithmetically by the 5-bit shift amount, rounding toward negative infinity; a shift of W or more yields all sign bits.
- R8: When the predicate bit is 0 on a legal op, the result carries `out_wen`=0 and `out_data` equal to the supplied old destination value.
- R9: Op codes 9 to 15, and any op code whose group is disabled by parameter, give `out_illegal`=1, `out_wen`=0 and `out_data` equal to the old destination value; a legal op with predicate 1 gives `out_illegal`=0 and `out_wen`=1.
- R10: With `out_ready` held high, a beat accepted on one rising edge appears on `out_valid` after the next rising edge, and one beat per cycle is sustained.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_wen` and `out_illegal` hold and no beat is lost; `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Lane can take a beat this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | W | First source element |
| in_b | input | W | Second source element |
| in_old | input | W | Current destination element value |
| in_shamt | input | 5 | Right-shift amount for the fixed-point multiply |
| in_pred | input | 1 | Predicate bit, 1 lets the result be written |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | W | Result element or old destination value |
| out_wen | output | 1 | Destination write-enable |
| out_illegal | output | 1 | Op code was unassigned or disabled |

## Verification
The bench aims at the numeric edges: adding one to the most positive value must wrap for plain add yet stick for saturating add, a design that shared one adder path wrongly would clamp both or wrap both. Absolute value of the most negative element and a fixed-point product that overflows the lane must clamp, where a careless design returns a negative or truncated number, and a negative product shifted right must round toward negative infinity, not toward zero. Masked and illegal beats must return the old value with no write-enable, which catches a mux that forwards the computed result. Random back-pressure and a held stall check that a result is neither dropped, duplicated nor altered while `out_ready` is low, and a single-beat timing check pins the two-edge latency.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MIN   = 4'd2,
    OP_MAX   = 4'd3,
    OP_ABS   = 4'd4,
    OP_MUL   = 4'd5,
    OP_SADD  = 4'd6,
    OP_SSUB  = 4'd7,
    OP_FXMUL = 4'd8
  } lane_op_e;

  localparam int OP_W    = 4;
  localparam int SHAMT_W = 5;

endpackage

// File: rtl/vlane_decode.sv
module vlane_decode
  import vlane_pkg::*;
#(
  parameter bit EN_ADDSUB = 1'b1,
  parameter bit EN_MINMAX = 1'b1,
  parameter bit EN_ABS    = 1'b1,
  parameter bit EN_MUL    = 1'b1,
  parameter bit EN_SAT    = 1'b1,
  parameter bit EN_FX     = 1'b1
) (
  input  logic [OP_W-1:0] op,
  output logic            illegal,
  output logic            mul_path
);

  always_comb begin
    illegal  = 1'b0;
    mul_path = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB:   illegal = !EN_ADDSUB;
      OP_MIN, OP_MAX:   illegal = !EN_MINMAX;
      OP_ABS:           illegal = !EN_ABS;
      OP_SADD, OP_SSUB: illegal = !EN_SAT;
      OP_MUL: begin
        illegal  = !EN_MUL;
        mul_path = 1'b1;
      end
      OP_FXMUL: begin
        illegal  = !EN_FX;
        mul_path = 1'b1;
      end
      default:          illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/vlane_mulstage.sv
module vlane_mulstage #(
  parameter int W      = 16,
  parameter bit EN_ANY = 1'b1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);

  generate
    if (EN_ANY) begin : g_mul
      logic signed [2*W-1:0] ax, bx;
      assign ax   = {{W{a[W-1]}}, a};
      assign bx   = {{W{b[W-1]}}, b};
      assign prod = ax * bx;
    end else begin : g_nomul
      assign prod = '0;
    end
  endgenerate

endmodule

// File: rtl/vlane_intops.sv
module vlane_intops
  import vlane_pkg::*;
#(
  parameter int W         = 16,
  parameter bit EN_ADDSUB = 1'b1,
  parameter bit EN_MINMAX = 1'b1,
  parameter bit EN_ABS    = 1'b1,
  parameter bit EN_SAT    = 1'b1
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res
);

  localparam longint SMAX_L = (64'sd1 <<< (W-1)) - 64'sd1;
  localparam longint SMIN_L = -(64'sd1 <<< (W-1));
  localparam logic signed [W:0]   HI_X = (W+1)'(SMAX_L);
  localparam logic signed [W:0]   LO_X = (W+1)'(SMIN_L);
  localparam logic        [W-1:0] HI   = W'(SMAX_L);
  localparam logic        [W-1:0] LO   = W'(SMIN_L);

  logic [W-1:0] add_r, sub_r, min_r, max_r, abs_r, sadd_r, ssub_r;

  // Shared widened sum and difference feed both wrap and clamp groups.
  logic signed [W:0] sum_x, dif_x;
  assign sum_x = $signed({a[W-1], a}) + $signed({b[W-1], b});
  assign dif_x = $signed({a[W-1], a}) - $signed({b[W-1], b});

  generate
    if (EN_ADDSUB) begin : g_addsub
      assign add_r = sum_x[W-1:0];
      assign sub_r = dif_x[W-1:0];
    end else begin : g_no_addsub
      assign add_r = '0;
      assign sub_r = '0;
    end

    if (EN_MINMAX) begin : g_minmax
      logic a_lt_b;
      assign a_lt_b = $signed(a) < $signed(b);
      assign min_r  = a_lt_b ? a : b;
      assign max_r  = a_lt_b ? b : a;
    end else begin : g_no_minmax
      assign min_r = '0;
      assign max_r = '0;
    end

    if (EN_ABS) begin : g_abs
      always_comb begin
        if (!a[W-1])    abs_r = a;
        else if (a == LO) abs_r = HI;
        else            abs_r = W'(-$signed(a));
      end
    end else begin : g_no_abs
      assign abs_r = '0;
    end

    if (EN_SAT) begin : g_sat
      always_comb begin
        if (sum_x > HI_X)      sadd_r = HI;
        else if (sum_x < LO_X) sadd_r = LO;
        else                   sadd_r = sum_x[W-1:0];
        if (dif_x > HI_X)      ssub_r = HI;
        else if (dif_x < LO_X) ssub_r = LO;
        else                   ssub_r = dif_x[W-1:0];
      end
    end else begin : g_no_sat
      assign sadd_r = '0;
      assign ssub_r = '0;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ADD:  res = add_r;
      OP_SUB:  res = sub_r;
      OP_MIN:  res = min_r;
      OP_MAX:  res = max_r;
      OP_ABS:  res = abs_r;
      OP_SADD: res = sadd_r;
      OP_SSUB: res = ssub_r;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/vlane_fxpost.sv
module vlane_fxpost
  import vlane_pkg::*;
#(
  parameter int W      = 16,
  parameter bit EN_MUL = 1'b1,
  parameter bit EN_FX  = 1'b1
) (
  input  logic [OP_W-1:0]    op,
  input  logic [2*W-1:0]     prod,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [W-1:0]       res
);

  localparam longint SMAX_L = (64'sd1 <<< (W-1)) - 64'sd1;
  localparam longint SMIN_L = -(64'sd1 <<< (W-1));
  localparam logic signed [2*W-1:0] HI_P = (2*W)'(SMAX_L);
  localparam logic signed [2*W-1:0] LO_P = (2*W)'(SMIN_L);

  logic [W-1:0] low_r, fx_r;

  generate
    if (EN_MUL) begin : g_low
      assign low_r = prod[W-1:0];
    end else begin : g_no_low
      assign low_r = '0;
    end

    if (EN_FX) begin : g_fx
      logic signed [W-1:0] clamped;
      always_comb begin
        if ($signed(prod) > HI_P)      clamped = W'(SMAX_L);
        else if ($signed(prod) < LO_P) clamped = W'(SMIN_L);
        else                           clamped = prod[W-1:0];
      end
      // Arithmetic shift: floors toward negative infinity, sign-fills past W.
      assign fx_r = clamped >>> shamt;
    end else begin : g_no_fx
      assign fx_r = '0;
    end
  endgenerate

  assign res = (op == OP_FXMUL) ? fx_r : low_r;

endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int W         = 16,
  parameter bit EN_ADDSUB = 1'b1,
  parameter bit EN_MINMAX = 1'b1,
  parameter bit EN_ABS    = 1'b1,
  parameter bit EN_MUL    = 1'b1,
  parameter bit EN_SAT    = 1'b1,
  parameter bit EN_FX     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_op,
  input  logic [W-1:0]       in_a,
  input  logic [W-1:0]       in_b,
  input  logic [W-1:0]       in_old,
  input  logic [SHAMT_W-1:0] in_shamt,
  input  logic               in_pred,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_data,
  output logic               out_wen,
  output logic               out_illegal
);

  localparam bit MUL_ANY = EN_MUL || EN_FX;

  // Whole pipeline advances together; it only stalls on a held result.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---------------- stage 1: decode and multiply ----------------
  logic             dec_ill, dec_mul;
  logic [2*W-1:0]   prod_c;

  vlane_decode #(
    .EN_ADDSUB(EN_ADDSUB), .EN_MINMAX(EN_MINMAX), .EN_ABS(EN_ABS),
    .EN_MUL(EN_MUL), .EN_SAT(EN_SAT), .EN_FX(EN_FX)
  ) u_dec (
    .op(in_op), .illegal(dec_ill), .mul_path(dec_mul)
  );

  vlane_mulstage #(.W(W), .EN_ANY(MUL_ANY)) u_mul (
    .a(in_a), .b(in_b), .prod(prod_c)
  );

  logic               s1_v, s1_ill, s1_mul, s1_pred;
  logic [OP_W-1:0]    s1_op;
  logic [W-1:0]       s1_a, s1_b, s1_old;
  logic [SHAMT_W-1:0] s1_sh;
  logic [2*W-1:0]     s1_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_ill  <= 1'b0;
      s1_mul  <= 1'b0;
      s1_pred <= 1'b0;
      s1_op   <= '0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_old  <= '0;
      s1_sh   <= '0;
      s1_prod <= '0;
    end else if (adv) begin
      s1_v    <= in_valid;
      s1_ill  <= dec_ill;
      s1_mul  <= dec_mul;
      s1_pred <= in_pred;
      s1_op   <= in_op;
      s1_a    <= in_a;
      s1_b    <= in_b;
      s1_old  <= in_old;
      s1_sh   <= in_shamt;
      s1_prod <= prod_c;
    end
  end

  // ---------------- stage 2: arithmetic, clamp, shift, select ----------------
  logic [W-1:0] int_res, mul_res, pick;

  vlane_intops #(
    .W(W), .EN_ADDSUB(EN_ADDSUB), .EN_MINMAX(EN_MINMAX),
    .EN_ABS(EN_ABS), .EN_SAT(EN_SAT)
  ) u_int (
    .op(s1_op), .a(s1_a), .b(s1_b), .res(int_res)
  );

  vlane_fxpost #(.W(W), .EN_MUL(EN_MUL), .EN_FX(EN_FX)) u_fx (
    .op(s1_op), .prod(s1_prod), .shamt(s1_sh), .res(mul_res)
  );

  logic keep_old;
  assign keep_old = s1_ill || !s1_pred;
  assign pick     = keep_old ? s1_old : (s1_mul ? mul_res : int_res);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (adv) begin
      out_valid   <= s1_v;
      out_data    <= pick;
      out_wen     <= s1_v && !keep_old;
      out_illegal <= s1_v && s1_ill;
    end
  end

endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_wen,
  input logic         out_illegal
);

  // R11: a held result keeps its payload
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_wen) && $stable(out_illegal));

  // R11: lane accepts whenever the output is free
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  // R9: an illegal op never writes
  p_ill_nowen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_wen);

  // R9: flags only travel with a valid result
  p_flags_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen || out_illegal) |-> out_valid);

  // R10: an accepted beat followed by an advancing cycle reaches the output
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) && in_ready |=> out_valid);

  // R1: reset empties the output stage
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind vlane_alu vlane_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_wen(out_wen), .out_illegal(out_illegal)
);

// File: tb/vlane_alu_test.sv
module vlane_alu_test;

  localparam int W = 16;
  localparam longint SMAX = (64'sd1 <<< (W-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0, in_old = '0;
  logic [4:0]   in_shamt = '0;
  logic         in_pred = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic         out_wen, out_illegal;

  always #10 clk = ~clk;  // 50 MHz

  vlane_alu #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_old(in_old),
    .in_shamt(in_shamt), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_wen(out_wen),
    .out_illegal(out_illegal)
  );

  typedef struct {
    logic [W-1:0] data;
    logic         wen;
    logic         ill;
    string        req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   rdy_mode = 0;  // 0 always ready, 1 random, 2 never
  int   cycles = 0;
  bit   done = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic longint sx(logic [W-1:0] v);
    logic signed [W-1:0] t;
    t = v;
    return longint'(t);
  endfunction

  function automatic longint clamp(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                                 logic [W-1:0] old, logic [4:0] sh, logic pred);
    exp_t   e;
    longint sa, sb, r;
    sa = sx(a);
    sb = sx(b);
    r  = 0;
    e.ill = (op > 4'd8);
    case (op)
      4'd0: begin r = sa + sb;                 e.req = "R2"; end
      4'd1: begin r = sa - sb;                 e.req = "R2"; end
      4'd2: begin r = (sa < sb) ? sa : sb;     e.req = "R3"; end
      4'd3: begin r = (sa < sb) ? sb : sa;     e.req = "R3"; end
      4'd4: begin r = clamp(sa < 0 ? -sa : sa); e.req = "R4"; end
      4'd5: begin r = sa * sb;                 e.req = "R5"; end
      4'd6: begin r = clamp(sa + sb);          e.req = "R6"; end
      4'd7: begin r = clamp(sa - sb);          e.req = "R6"; end
      4'd8: begin r = clamp(sa * sb) >>> sh;   e.req = "R7"; end
      default:                                 e.req = "R9";
    endcase
    if (e.ill || !pred) begin
      e.data = old;
      e.wen  = 1'b0;
      if (!e.ill) e.req = "R8";
    end else begin
      e.data = W'(r);
      e.wen  = 1'b1;
    end
    return e;
  endfunction

  // Driver: hold the beat until it is taken, then push its expectation.
  task automatic send(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                      logic [W-1:0] old, logic [4:0] sh, logic pred);
    bit taken;
    do begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op = op; in_a = a; in_b = b; in_old = old; in_shamt = sh; in_pred = pred;
      #2;
      taken = in_ready;
      if (taken) q.push_back(model(op, a, b, old, sh, pred));
      @(posedge clk);
    end while (!taken);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-pressure source
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom_range(0, 3) != 0);
      default: out_ready = 1'b0;
    endcase
  end

  // Monitor: compare each result that leaves on the next edge.
  always @(negedge clk) begin
    #4;
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", longint'(out_data), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(out_data == e.data && out_wen == e.wen && out_illegal == e.ill, e.req,
              "data/wen/illegal",
              longint'({out_data, out_wen, out_illegal}),
              longint'({e.data, e.wen, e.ill}));
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic drain();
    rdy_mode = 0;
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R10: single-beat latency
    send(4'd0, 16'd5, 16'd6, 16'd0, 5'd0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    #3;
    check(out_valid == 1'b0, "R10", "valid one edge after accept", out_valid, 0);
    @(negedge clk);
    #3;
    check(out_valid == 1'b1, "R10", "valid two edges after accept", out_valid, 1);
    check(out_data == 16'd11, "R10", "latency data", out_data, 11);
    drain();

    // Directed corners, back-to-back
    send(4'd0, 16'h7fff, 16'h0001, 16'h0, 5'd0, 1'b1);  // R2 wrap up
    send(4'd1, 16'h8000, 16'h0001, 16'h0, 5'd0, 1'b1);  // R2 wrap down
    send(4'd2, 16'hfffb, 16'h0003, 16'h0, 5'd0, 1'b1);  // R3 min -5
    send(4'd3, 16'hfffb, 16'h0003, 16'h0, 5'd0, 1'b1);  // R3 max 3
    send(4'd4, 16'hfff9, 16'h0, 16'h0, 5'd0, 1'b1);     // R4 abs -7
    send(4'd4, 16'h8000, 16'h0, 16'h0, 5'd0, 1'b1);     // R4 most negative
    send(4'd5, 16'd300, 16'd300, 16'h0, 5'd0, 1'b1);    // R5 low half
    send(4'd5, 16'hfffd, 16'd5, 16'h0, 5'd0, 1'b1);     // R5 negative
    send(4'd6, 16'h7000, 16'h2000, 16'h0, 5'd0, 1'b1);  // R6 clamp high
    send(4'd6, 16'h8000, 16'hffff, 16'h0, 5'd0, 1'b1);  // R6 clamp low
    send(4'd7, 16'h8000, 16'h0001, 16'h0, 5'd0, 1'b1);  // R6 sub clamp
    send(4'd7, 16'd100, 16'd30, 16'h0, 5'd0, 1'b1);     // R6 in range
    send(4'd8, 16'h4000, 16'h4000, 16'h0, 5'd3, 1'b1);  // R7 clamp then shift
    send(4'd8, 16'hfffd, 16'd5, 16'h0, 5'd2, 1'b1);     // R7 floor -15>>2=-4
    send(4'd8, 16'd100, 16'd100, 16'h0, 5'd31, 1'b1);   // R7 shift past W
    send(4'd8, 16'hffff, 16'd1, 16'h0, 5'd20, 1'b1);    // R7 sign fill
    send(4'd0, 16'd1, 16'd2, 16'hbeef, 5'd0, 1'b0);     // R8 masked
    send(4'd8, 16'd7, 16'd7, 16'h1234, 5'd1, 1'b0);     // R8 masked mul
    send(4'd9, 16'd1, 16'd2, 16'hcafe, 5'd0, 1'b1);     // R9 illegal
    send(4'd15, 16'd1, 16'd2, 16'h0f0f, 5'd0, 1'b0);    // R9 illegal masked
    idle();
    drain();

    // R11: held stall
    rdy_mode = 2;
    send(4'd0, 16'd1, 16'd2, 16'h0, 5'd0, 1'b1);
    send(4'd1, 16'd9, 16'd4, 16'h0, 5'd0, 1'b1);
    idle();
    repeat (3) @(negedge clk);
    #3;
    held = out_data;
    check(out_valid == 1'b1, "R11", "valid while stalled", out_valid, 1);
    check(in_ready == 1'b0, "R11", "ready low when full", in_ready, 0);
    check(out_data == 16'd3, "R11", "stalled data", out_data, 3);
    @(negedge clk);
    #3;
    check(out_data == held, "R11", "data held", out_data, held);
    drain();

    // Random traffic under random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 400; i++) begin
      send(4'($urandom_range(0, 10)), W'($urandom), W'($urandom), W'($urandom),
           5'($urandom), ($urandom_range(0, 4) != 0));
      if (i % 37 == 0) idle();
    end
    idle();
    drain();

    done = 1'b1;
    finish_run();
  end

endmodule